// File: doc/BRIEF.md
# Link Lane Count and Rate Selector

This block picks the lane count and the link rate for a display link that must carry a requested pixel clock. Before it starts, the caller supplies the sink's maximum rate code, its maximum lane count and a flag that says whether the sink is DP1.2-capable. Bits per pixel are fixed at 24. A candidate configuration is accepted when `pixel_clock * 24 <= rate * lanes * 8`. The block computes that product with a shift-add structure and compares it against the pixel clock times 24, so no divider is needed.

The search runs in two phases. The lane phase holds the rate at the sink's maximum and tries lane counts in ascending powers of two. The rate phase holds the chosen lane count and walks the rates from lowest to highest. Each candidate takes one clock cycle. A start pulse begins a computation. A one-cycle done pulse marks the moment the results become valid, and the results then stay unchanged until the next accepted start. A mode-valid flag tells the caller when the chosen rate is one the sink may not run.

Top module: `dp_link_sel`

## Requirements
- R1: After reset, `done`, `busy`, `mode_ok`, `lane_count`, `rate_khz` and `rate_code` are all 0.
- R2: The sink maximum rate code is decoded as 8'h06 to 162000, 8'h0A to 270000 and 8'h14 to 540000. Any other code is decoded as 162000.
- R3: `sink_lane_max` gives the sink's maximum lane count. A value of 0 is treated as 1.
- R4: The lane count is the first of 1, 2, 4, 8, 16 that is below the maximum lane count and whose capacity at the sink's maximum rate covers the pixel clock. If no such count exists, the lane count is the maximum lane count.
- R5: At the chosen lane count, the rate is 162000 if that covers the pixel clock, otherwise 270000 if that covers it.
- R6: 540000 is tried after 270000 only when `dp12_cap` is 1.
- R7: When no tried rate covers the pixel clock, the rate is the decoded sink maximum rate.
- R8: `rate_code` is 8'h06, 8'h0A or 8'h14 for a rate of 162000, 270000 or 540000 respectively.
- R9: `mode_ok` is 0 exactly when the chosen rate is 540000 and `dp12_cap` is 0. Otherwise it is 1.
- R10: A `start` that arrives while idle is accepted, and `busy` is high in the next cycle. A `start` that arrives while busy is ignored. `done` is a one-cycle pulse, and the outputs keep their values until the next accepted start.
- R11: `done` arrives no more than 10 clock cycles after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| pix_khz | input | 20 | Requested pixel clock in kHz |
| sink_rate_code | input | 8 | Sink maximum link rate code |
| sink_lane_max | input | 5 | Sink maximum lane count |
| dp12_cap | input | 1 | Sink is DP1.2-capable |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| lane_count | output | 5 | Chosen lane count |
| rate_khz | output | 20 | Chosen link rate in kHz |
| rate_code | output | 8 | Code of the chosen link rate |
| mode_ok | output | 1 | Chosen configuration is allowed for this sink |

## Verification
A wrong search state would show up at the ports in the same `done` cycle as a lane count or rate that disagrees with the reference selection. The most likely cases are an extra or missing doubling, a skipped rate step, or a 540000 pick on a sink that is not DP1.2-capable. Equality boundaries, where the capacity exactly matches the demand, expose an off-by-one in the comparison. A stuck sequencer shows up as a missing `done` within the latency bound. A leak from the inputs shows up as outputs that change while idle, or as a result that follows a `start` issued while busy.

// File: rtl/dp_link_sel_pkg.sv
package dp_link_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LANE = 2'd1,
        ST_RATE = 2'd2,
        ST_DONE = 2'd3
    } sel_state_e;

    localparam int RATE_LO_KHZ  = 162000;
    localparam int RATE_MID_KHZ = 270000;
    localparam int RATE_HI_KHZ  = 540000;

    localparam logic [7:0] CODE_LO  = 8'h06;
    localparam logic [7:0] CODE_MID = 8'h0A;
    localparam logic [7:0] CODE_HI  = 8'h14;

    localparam int BPP       = 24;
    localparam int BITS_PER_SYMBOL = 8;

endpackage

// File: rtl/dp_link_sel_rate_table.sv
module dp_link_sel_rate_table
    import dp_link_sel_pkg::*;
#(
    parameter int RATE_W = 20
) (
    input  logic [7:0]        sink_code,
    input  logic [1:0]        step_idx,
    output logic [RATE_W-1:0] sink_khz,
    output logic [7:0]        sink_code_norm,
    output logic [RATE_W-1:0] step_khz,
    output logic [7:0]        step_code
);

    // decode of the sink's capability code; unknown codes fall to the lowest rate
    always_comb begin
        case (sink_code)
            CODE_MID: begin
                sink_khz       = RATE_W'(RATE_MID_KHZ);
                sink_code_norm = CODE_MID;
            end
            CODE_HI: begin
                sink_khz       = RATE_W'(RATE_HI_KHZ);
                sink_code_norm = CODE_HI;
            end
            default: begin
                sink_khz       = RATE_W'(RATE_LO_KHZ);
                sink_code_norm = CODE_LO;
            end
        endcase
    end

    // ascending rate ladder walked by the rate phase
    always_comb begin
        case (step_idx)
            2'd1: begin
                step_khz  = RATE_W'(RATE_MID_KHZ);
                step_code = CODE_MID;
            end
            2'd2: begin
                step_khz  = RATE_W'(RATE_HI_KHZ);
                step_code = CODE_HI;
            end
            default: begin
                step_khz  = RATE_W'(RATE_LO_KHZ);
                step_code = CODE_LO;
            end
        endcase
    end

endmodule

// File: rtl/dp_link_sel_capacity.sv
module dp_link_sel_capacity #(
    parameter int RATE_W = 20,
    parameter int MUL_W  = 6,
    parameter int CAP_W  = 32,
    parameter int SYM_SH = 3
) (
    input  logic [RATE_W-1:0] rate_khz,
    input  logic [MUL_W-1:0]  lanes,
    input  logic [CAP_W-1:0]  demand,
    output logic              fits
);

    logic [CAP_W-1:0] partial [MUL_W];
    logic [CAP_W-1:0] capacity;

    // one shifted copy of the rate per lane-count bit, pre-scaled by bits per symbol
    for (genvar gi = 0; gi < MUL_W; gi++) begin : g_pp
        assign partial[gi] = lanes[gi] ? (CAP_W'(rate_khz) << (gi + SYM_SH)) : '0;
    end

    always_comb begin
        capacity = '0;
        for (int k = 0; k < MUL_W; k++) begin
            capacity = capacity + partial[k];
        end
    end

    assign fits = (demand <= capacity);

endmodule

// File: rtl/dp_link_sel.sv
module dp_link_sel
    import dp_link_sel_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int RATE_W = 20,
    parameter int LANE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIX_W-1:0]  pix_khz,
    input  logic [7:0]        sink_rate_code,
    input  logic [LANE_W-1:0] sink_lane_max,
    input  logic              dp12_cap,
    output logic              busy,
    output logic              done,
    output logic [LANE_W-1:0] lane_count,
    output logic [RATE_W-1:0] rate_khz,
    output logic [7:0]        rate_code,
    output logic              mode_ok
);

    localparam int MUL_W  = LANE_W + 1;
    localparam int SYM_SH = $clog2(BITS_PER_SYMBOL);
    localparam int CAP_A  = RATE_W + MUL_W + SYM_SH + 1;
    localparam int CAP_B  = PIX_W + $clog2(BPP) + 1;
    localparam int CAP_W  = (CAP_A > CAP_B) ? CAP_A : CAP_B;

    typedef struct packed {
        sel_state_e        st;
        logic [CAP_W-1:0]  demand;
        logic [RATE_W-1:0] srate;
        logic [7:0]        scode;
        logic [LANE_W-1:0] smax;
        logic              dp12;
        logic [MUL_W-1:0]  cand;
        logic [1:0]        ridx;
        logic [LANE_W-1:0] lanes;
        logic [RATE_W-1:0] rate;
        logic [7:0]        code;
        logic              ok;
    } sel_regs_t;

    sel_regs_t r_q, r_d;

    logic [RATE_W-1:0] sink_khz;
    logic [7:0]        sink_code_norm;
    logic [RATE_W-1:0] step_khz;
    logic [7:0]        step_code;
    logic [RATE_W-1:0] cap_rate;
    logic [MUL_W-1:0]  cap_lanes;
    logic              cap_fits;
    logic [CAP_W-1:0]  pix_x24;

    dp_link_sel_rate_table #(
        .RATE_W (RATE_W)
    ) table_i (
        .sink_code      (sink_rate_code),
        .step_idx       (r_q.ridx),
        .sink_khz       (sink_khz),
        .sink_code_norm (sink_code_norm),
        .step_khz       (step_khz),
        .step_code      (step_code)
    );

    // operand steering: lane phase tests at the sink maximum, rate phase at the chosen lanes
    always_comb begin
        if (r_q.st == ST_LANE) begin
            cap_rate  = r_q.srate;
            cap_lanes = r_q.cand;
        end else begin
            cap_rate  = step_khz;
            cap_lanes = {1'b0, r_q.lanes};
        end
    end

    dp_link_sel_capacity #(
        .RATE_W (RATE_W),
        .MUL_W  (MUL_W),
        .CAP_W  (CAP_W),
        .SYM_SH (SYM_SH)
    ) cap_i (
        .rate_khz (cap_rate),
        .lanes    (cap_lanes),
        .demand   (r_q.demand),
        .fits     (cap_fits)
    );

    // demand = pixel clock * 24, built from shifts
    assign pix_x24 = (CAP_W'(pix_khz) << 4) + (CAP_W'(pix_khz) << 3);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_LANE;
                    r_d.demand = pix_x24;
                    r_d.srate  = sink_khz;
                    r_d.scode  = sink_code_norm;
                    r_d.smax   = (sink_lane_max == '0) ? LANE_W'(1) : sink_lane_max;
                    r_d.dp12   = dp12_cap;
                    r_d.cand   = MUL_W'(1);
                    r_d.ridx   = 2'd0;
                end
            end
            ST_LANE: begin
                if (r_q.cand >= {1'b0, r_q.smax}) begin
                    r_d.lanes = r_q.smax;
                    r_d.st    = ST_RATE;
                end else if (cap_fits) begin
                    r_d.lanes = r_q.cand[LANE_W-1:0];
                    r_d.st    = ST_RATE;
                end else begin
                    r_d.cand  = r_q.cand << 1;
                end
            end
            ST_RATE: begin
                if (cap_fits) begin
                    r_d.rate = step_khz;
                    r_d.code = step_code;
                    r_d.ok   = !((step_code == CODE_HI) && !r_q.dp12);
                    r_d.st   = ST_DONE;
                end else if ((r_q.ridx == 2'd0) || ((r_q.ridx == 2'd1) && r_q.dp12)) begin
                    r_d.ridx = r_q.ridx + 2'd1;
                end else begin
                    r_d.rate = r_q.srate;
                    r_d.code = r_q.scode;
                    r_d.ok   = !((r_q.scode == CODE_HI) && !r_q.dp12);
                    r_d.st   = ST_DONE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st == ST_LANE) || (r_q.st == ST_RATE);
    assign done       = (r_q.st == ST_DONE);
    assign lane_count = r_q.lanes;
    assign rate_khz   = r_q.rate;
    assign rate_code  = r_q.code;
    assign mode_ok    = r_q.ok;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) else $error("busy and done together"); // R10

    AST_LANES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lane_count != '0) && (lane_count <= r_q.smax)) else $error("lanes out of range"); // R4

    AST_CODE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rate_khz == RATE_W'(RATE_LO_KHZ))  && (rate_code == CODE_LO))  ||
                 ((rate_khz == RATE_W'(RATE_MID_KHZ)) && (rate_code == CODE_MID)) ||
                 ((rate_khz == RATE_W'(RATE_HI_KHZ))  && (rate_code == CODE_HI)))
        else $error("rate and code disagree"); // R8

    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rate_khz == RATE_W'(RATE_HI_KHZ)) && !r_q.dp12) |-> !mode_ok)
        else $error("540000 on non-capable sink reported valid"); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(rate_khz) && $stable(lane_count) && $stable(mode_ok))
        else $error("outputs moved while idle"); // R10

endmodule

// File: tb/dp_link_sel_tb_top.sv
module dp_link_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] pix_khz = '0;
    logic [7:0]  sink_rate_code = '0;
    logic [4:0]  sink_lane_max = '0;
    logic        dp12_cap = 1'b0;
    logic        busy, done, mode_ok;
    logic [4:0]  lane_count;
    logic [19:0] rate_khz;
    logic [7:0]  rate_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dp_link_sel dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .pix_khz        (pix_khz),
        .sink_rate_code (sink_rate_code),
        .sink_lane_max  (sink_lane_max),
        .dp12_cap       (dp12_cap),
        .busy           (busy),
        .done           (done),
        .lane_count     (lane_count),
        .rate_khz       (rate_khz),
        .rate_code      (rate_code),
        .mode_ok        (mode_ok)
    );

    function automatic longint dec_rate(input logic [7:0] c);
        if (c == 8'h0A) return 270000;
        if (c == 8'h14) return 540000;
        return 162000;
    endfunction

    function automatic logic fits(input longint pix, input longint r, input longint l);
        return (pix * 24) <= (r * l * 8);
    endfunction

    function automatic longint ref_lanes(input longint pix, input logic [7:0] c, input logic [4:0] m);
        longint mx = (m == 0) ? 1 : m;
        longint l = 1;
        while (l < mx) begin
            if (fits(pix, dec_rate(c), l)) return l;
            l = l * 2;
        end
        return mx;
    endfunction

    function automatic longint ref_rate(input longint pix, input logic [7:0] c, input logic [4:0] m, input logic d12);
        longint l = ref_lanes(pix, c, m);
        if (fits(pix, 162000, l)) return 162000;
        if (fits(pix, 270000, l)) return 270000;
        if (d12 && fits(pix, 540000, l)) return 540000;
        return dec_rate(c);
    endfunction

    function automatic longint ref_code(input longint r);
        if (r == 270000) return 8'h0A;
        if (r == 540000) return 8'h14;
        return 8'h06;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request; returns cycles from accepting edge to done
    task automatic run(input logic [19:0] p, input logic [7:0] c, input logic [4:0] m, input logic d, output int lat);
        @(negedge clk);
        pix_khz = p; sink_rate_code = c; sink_lane_max = m; dp12_cap = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", busy, 1);
        lat = 1;
        while (!done && lat < 30) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input string tag, input logic [19:0] p, input logic [7:0] c, input logic [4:0] m, input logic d, input int lat);
        longint er = ref_rate(p, c, m, d);
        chk({tag, " R11 latency"}, (lat <= 10) ? 1 : 0, 1);
        chk({tag, " R4 lanes"}, lane_count, ref_lanes(p, c, m));
        chk({tag, " R5 rate"}, rate_khz, er);
        chk({tag, " R8 code"}, rate_code, ref_code(er));
        chk({tag, " R9 mode_ok"}, mode_ok, (er == 540000 && !d) ? 0 : 1);
    endtask

    task automatic one(input string tag, input logic [19:0] p, input logic [7:0] c, input logic [4:0] m, input logic d);
        int lat;
        run(p, c, m, d, lat);
        check_result(tag, p, c, m, d, lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        logic [7:0] codes [4];
        void'($urandom(32'd1234));
        codes[0] = 8'h06; codes[1] = 8'h0A; codes[2] = 8'h14; codes[3] = 8'h33;

        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mode_ok", mode_ok, 0);
        chk("R1 lanes", lane_count, 0);
        chk("R1 rate", rate_khz, 0);
        chk("R1 code", rate_code, 0);
        rst_n = 1'b1;

        // R2 decoding: unknown code treated as lowest rate
        one("R2 unknown", 20'd100000, 8'h55, 5'd1, 1'b0);
        chk("R2 unknown falls to 162000", rate_khz, 162000);
        one("R2 code0A", 20'd100000, 8'h0A, 5'd1, 1'b0);
        chk("R2 0A -> 270000", rate_khz, 270000);
        // R3 zero max lanes acts as one lane
        one("R3 zero", 20'd500000, 8'h0A, 5'd0, 1'b0);
        chk("R3 zero max -> 1 lane", lane_count, 1);
        // R4 boundary: exactly fits one lane at 162000
        one("R4 edge", 20'd54000, 8'h06, 5'd4, 1'b0);
        chk("R4 equality fits one lane", lane_count, 1);
        one("R4 edge+1", 20'd54001, 8'h06, 5'd4, 1'b0);
        chk("R4 one over -> 2 lanes", lane_count, 2);
        // R4 non-power-of-two maximum
        one("R4 max3", 20'd200000, 8'h06, 5'd3, 1'b0);
        chk("R4 max 3 used", lane_count, 3);
        // R6/R7/R9: 540000 blocked without DP1.2, fallback to sink maximum
        one("R7 fallback", 20'd100000, 8'h14, 5'd1, 1'b0);
        chk("R7 fallback rate", rate_khz, 540000);
        chk("R9 not valid", mode_ok, 0);
        one("R6 capable", 20'd100000, 8'h14, 5'd1, 1'b1);
        chk("R6 540000 chosen", rate_khz, 540000);
        chk("R9 valid", mode_ok, 1);
        one("R7 lowmax", 20'd900000, 8'h06, 5'd1, 1'b1);
        chk("R7 fallback to 162000", rate_khz, 162000);

        // R10 start while busy is ignored
        @(negedge clk);
        pix_khz = 20'd54001; sink_rate_code = 8'h06; sink_lane_max = 5'd8; dp12_cap = 1'b0;
        start = 1'b1;
        @(negedge clk);
        pix_khz = 20'd1000; sink_rate_code = 8'h14; sink_lane_max = 5'd1; dp12_cap = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 30) begin @(negedge clk); lat++; end
        check_result("R10 busy-start", 20'd54001, 8'h06, 5'd8, 1'b0, lat);
        // R10 done one cycle, results held while idle
        @(negedge clk);
        chk("R10 done pulse", done, 0);
        pix_khz = 20'd999999; sink_rate_code = 8'h14; sink_lane_max = 5'd31;
        repeat (4) @(negedge clk);
        chk("R10 held lanes", lane_count, 2);
        chk("R10 held rate", rate_khz, 162000);

        for (int i = 0; i < 300; i++) begin
            logic [19:0] p = 20'($urandom_range(1, 1048575));
            logic [7:0]  c = codes[$urandom_range(0, 3)];
            logic [4:0]  m = 5'($urandom_range(0, 31));
            logic        d = 1'($urandom_range(0, 1));
            if (i % 3 == 0) p = 20'($urandom_range(1, 400000));
            one("random", p, c, m, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule